// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of transfers without help once it is started. Software first fills three small tables: a command table, a transmit table and a receive table. The command table sets the chip-select pattern for each entry and whether the entry uses the programmable word length. Software also sets the first and last entry indexes. It then writes the go bit. The controller fetches each entry in turn and drives the chip-select lines that the entry names. It shifts the transmit word out most significant bit first. It stores the word received at the same time into the receive table at the same index. After the last entry it raises a done flag.

When no queue is running, the SCK and chip-select pins are driven from an idle-level register that software writes. Software should set that register to the inactive SPI levels so that the handover makes no glitch. The block supports all four clock polarity and phase combinations, word lengths from 8 to 16 bits, and a clock divider. It flags a mode fault when its slave-select input is pulled low. A fault halts a running queue at once.

All configuration goes through one write port. `cfg_sel` picks the target: 0 is the mode register, 1 the queue register, 2 the idle-level register, 3 the flag-clear register, 4 the command table and 5 the transmit table. The receive table is read through `rx_idx` and `rx_rdata`, with one cycle of latency.

Top module: `spiq_master`

## Requirements
- R1: After reset, `sck_o` is 0, `mosi_o` is 0, `cs_n_o` is all ones, and `busy`, `done` and `fault` are 0.
- R2: While no queue runs, `sck_o` follows idle-register bit 0 and `cs_n_o` follows idle-register bits 4:1. The pins take the new value within two cycles of the write.
- R3: Data leaves on `mosi_o` most significant bit first. An entry whose command bit 4 (length enable) is clear moves 8 bits, taken from the low 8 bits of the transmit word.
- R4: With length enable set, the length comes from mode bits 5:2. A code of 8 to 15 gives that many bits, 0 gives 16, and 1 to 7 give 8.
- R5: Mode bit 0 (polarity) sets the level that SCK rests at. Mode bit 1 (phase) set to 0 means data is sampled on the first edge of each bit. Set to 1, data is launched on the first edge and sampled on the second. All four combinations move data correctly in both directions.
- R6: The received word is written, right-aligned, to the receive table at the index of the entry that sent it.
- R7: Writing queue bit 15 starts execution at the index in queue bits 3:0. The queue steps upward, wrapping from 15 to 0, and runs through the entry in queue bits 7:4 inclusive. It then sets `done`, clears `busy` and gives the pins back to the idle levels.
- R8: Each SCK half-period lasts the value in mode bits 15:8 in system clocks, with 2 as the floor. So SCK is at most one quarter of the system clock.
- R9: During an entry, chip-select holds the command bits 3:0 pattern steady. It is active for at least one half-period before the first SCK edge and after the last one.
- R10: A low `ss_n` sets the sticky `fault` flag and stops a running queue, returning the pins to the idle levels. Start requests are ignored while `fault` is set. Writing 1 to flag-clear bit 1 clears `fault`, and bit 0 clears `done`.
- R11: Each entry drives `cs_n_o` with the pattern in its own command bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Write target select |
| cfg_idx | input | 4 | Table index for table writes |
| cfg_wdata | input | 16 | Write data |
| rx_idx | input | 4 | Receive table read index |
| rx_rdata | output | 16 | Receive table read data, one cycle after `rx_idx` |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select input; low means mode fault |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 4 | Chip-select outputs |
| busy | output | 1 | Queue running |
| done | output | 1 | Sticky queue-complete flag |
| fault | output | 1 | Sticky mode-fault flag |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 16-entry queue, four chip-selects and an 8-bit half-period field. With these values the bench can reach the wrap from entry 15 to entry 0 and the full 16-bit length. It also reaches the divide-by-4 floor when a half-period of 1 is requested. A bench slave that follows the programmed polarity and phase checks both directions of data flow in all four modes. It also times the lead, lag and half-period from the pins.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  typedef enum logic [1:0] {Q_IDLE, Q_FETCH, Q_LAUNCH, Q_RUN} q_state_e;
  typedef enum logic [1:0] {E_IDLE, E_EDGE, E_LAG} e_state_e;
  localparam logic [2:0] SEL_MODE  = 3'd0;
  localparam logic [2:0] SEL_QUEUE = 3'd1;
  localparam logic [2:0] SEL_IDLE  = 3'd2;
  localparam logic [2:0] SEL_CLR   = 3'd3;
  localparam logic [2:0] SEL_CMD   = 3'd4;
  localparam logic [2:0] SEL_TX    = 3'd5;
endpackage

// File: rtl/spiq_ram.sv
module spiq_ram #(
  parameter int W = 16,
  parameter int D = 16,
  localparam int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spiq_engine.sv
module spiq_engine import spiq_pkg::*; #(
  parameter int DW  = 16,
  parameter int HPW = 8,
  localparam int LW = $clog2(DW + 1),
  localparam int EW = LW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           abort,
  input  logic           cpol,
  input  logic           cpha,
  input  logic [LW-1:0]  len,
  input  logic [HPW-1:0] hp,
  input  logic [DW-1:0]  tx,
  input  logic           miso,
  output logic           sck,
  output logic           mosi,
  output logic           done,
  output logic [DW-1:0]  rx
);
  e_state_e       st;
  logic [HPW-1:0] cnt;
  logic [EW-1:0]  edge_n;
  logic [DW-1:0]  sh;
  logic [LW-1:0]  nb;
  logic           pol, pha;
  logic [HPW-1:0] hpe;
  logic           tick;
  logic [EW-1:0]  k;
  logic [LW-1:0]  sa;

  assign hpe  = (hp < HPW'(2)) ? HPW'(2) : hp;
  assign tick = (cnt == hpe - HPW'(1));
  assign k    = edge_n + EW'(1);
  assign sa   = LW'(DW) - len;
  assign mosi = sh[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= E_IDLE; cnt <= '0; edge_n <= '0; sh <= '0; rx <= '0;
      nb <= '0; pol <= 1'b0; pha <= 1'b0; sck <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        E_IDLE: begin
          sck <= cpol;
          if (start) begin
            pol <= cpol; pha <= cpha; nb <= len;
            sh <= tx << sa; rx <= '0; cnt <= '0; edge_n <= '0;
            st <= E_EDGE;
          end
        end
        E_EDGE: begin
          if (tick) begin
            cnt <= '0;
            edge_n <= k;
            sck <= ~sck;
            if (pha == 1'b0) begin
              if (k[0]) rx <= {rx[DW-2:0], miso};
              else if (k != {nb, 1'b0}) sh <= sh << 1;
            end else begin
              if (!k[0]) rx <= {rx[DW-2:0], miso};
              else if (k != EW'(1)) sh <= sh << 1;
            end
            if (k == {nb, 1'b0}) st <= E_LAG;
          end else begin
            cnt <= cnt + HPW'(1);
          end
        end
        E_LAG: begin
          if (tick) begin
            done <= 1'b1;
            st <= E_IDLE;
          end else begin
            cnt <= cnt + HPW'(1);
          end
        end
        default: st <= E_IDLE;
      endcase
      if (abort) st <= E_IDLE;
    end
  end

  assert_sck_min_half_R8: assert property (@(posedge clk) disable iff (rst)
    (st != E_IDLE && !$stable(sck)) |-> ($past(sck) == $past(sck, 2)));
  assert_bit_count_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (edge_n == {nb, 1'b0} && sck == pol));
endmodule

// File: rtl/spiq_master.sv
module spiq_master import spiq_pkg::*; #(
  parameter int DW     = 16,
  parameter int QDEPTH = 16,
  parameter int NCS    = 4,
  parameter int HPW    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [2:0]                cfg_sel,
  input  logic [$clog2(QDEPTH)-1:0] cfg_idx,
  input  logic [DW-1:0]             cfg_wdata,
  input  logic [$clog2(QDEPTH)-1:0] rx_idx,
  output logic [DW-1:0]             rx_rdata,
  input  logic                      miso,
  input  logic                      ss_n,
  output logic                      sck_o,
  output logic                      mosi_o,
  output logic [NCS-1:0]            cs_n_o,
  output logic                      busy,
  output logic                      done,
  output logic                      fault
);
  localparam int QAW    = $clog2(QDEPTH);
  localparam int LW     = $clog2(DW + 1);
  localparam int CW     = $clog2(DW);
  localparam int HP_LSB = DW - HPW;

  q_state_e       state;
  logic [QAW-1:0] ptr, nqp_r, endp_r;
  logic           cpol_r, cpha_r, idle_sck, ss_q;
  logic [CW-1:0]  code_r;
  logic [HPW-1:0] hp_r;
  logic [NCS-1:0] idle_cs, cs_act;
  logic [NCS:0]   cmd_q;
  logic [DW-1:0]  tx_q, eng_rx;
  logic [LW-1:0]  len_cur;
  logic           eng_sck, eng_mosi, eng_done, go_req;

  function automatic logic [LW-1:0] len_of(input logic [CW-1:0] c);
    if (c == '0) return LW'(DW);
    else if (c < CW'(8)) return LW'(8);
    else return LW'(c);
  endfunction

  assign len_cur = cmd_q[NCS] ? len_of(code_r) : LW'(8);
  assign go_req  = cfg_we && cfg_sel == SEL_QUEUE && cfg_wdata[DW-1];
  assign busy    = (state != Q_IDLE);

  spiq_ram #(.W(NCS + 1), .D(QDEPTH)) u_cmd (
    .clk, .we(cfg_we && cfg_sel == SEL_CMD), .waddr(cfg_idx),
    .wdata(cfg_wdata[NCS:0]), .raddr(ptr), .rdata(cmd_q));
  spiq_ram #(.W(DW), .D(QDEPTH)) u_tx (
    .clk, .we(cfg_we && cfg_sel == SEL_TX), .waddr(cfg_idx),
    .wdata(cfg_wdata), .raddr(ptr), .rdata(tx_q));
  spiq_ram #(.W(DW), .D(QDEPTH)) u_rx (
    .clk, .we(eng_done && state == Q_RUN), .waddr(ptr),
    .wdata(eng_rx), .raddr(rx_idx), .rdata(rx_rdata));

  spiq_engine #(.DW(DW), .HPW(HPW)) u_eng (
    .clk, .rst, .start(state == Q_LAUNCH), .abort(!ss_q),
    .cpol(cpol_r), .cpha(cpha_r), .len(len_cur), .hp(hp_r), .tx(tx_q),
    .miso, .sck(eng_sck), .mosi(eng_mosi), .done(eng_done), .rx(eng_rx));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= Q_IDLE; ptr <= '0; nqp_r <= '0; endp_r <= '0;
      cpol_r <= 1'b0; cpha_r <= 1'b0; code_r <= '0; hp_r <= HPW'(2);
      idle_sck <= 1'b0; idle_cs <= '1; cs_act <= '1; ss_q <= 1'b1;
      done <= 1'b0; fault <= 1'b0;
      sck_o <= 1'b0; mosi_o <= 1'b0; cs_n_o <= '1;
    end else begin
      ss_q <= ss_n;
      if (cfg_we) begin
        unique case (cfg_sel)
          SEL_MODE: begin
            cpol_r <= cfg_wdata[0]; cpha_r <= cfg_wdata[1];
            code_r <= cfg_wdata[2 +: CW]; hp_r <= cfg_wdata[HP_LSB +: HPW];
          end
          SEL_QUEUE: begin
            nqp_r <= cfg_wdata[QAW-1:0]; endp_r <= cfg_wdata[2*QAW-1:QAW];
          end
          SEL_IDLE: begin
            idle_sck <= cfg_wdata[0]; idle_cs <= cfg_wdata[NCS:1];
          end
          SEL_CLR: begin
            if (cfg_wdata[0]) done <= 1'b0;
            if (cfg_wdata[1]) fault <= 1'b0;
          end
          default: ;
        endcase
      end
      unique case (state)
        Q_IDLE: if (go_req && !fault) begin
          ptr <= cfg_wdata[QAW-1:0]; endp_r <= cfg_wdata[2*QAW-1:QAW];
          done <= 1'b0; cs_act <= idle_cs; state <= Q_FETCH;
        end
        Q_FETCH:  state <= Q_LAUNCH;
        Q_LAUNCH: begin cs_act <= cmd_q[NCS-1:0]; state <= Q_RUN; end
        Q_RUN: if (eng_done) begin
          if (ptr == endp_r) begin done <= 1'b1; state <= Q_IDLE; end
          else begin ptr <= ptr + QAW'(1); state <= Q_FETCH; end
        end
        default: state <= Q_IDLE;
      endcase
      if (!ss_q) begin
        fault <= 1'b1;
        state <= Q_IDLE;
      end
      sck_o  <= busy ? eng_sck  : idle_sck;
      mosi_o <= busy ? eng_mosi : 1'b0;
      cs_n_o <= busy ? cs_act   : idle_cs;
    end
  end

  assert_fault_halts_R10: assert property (@(posedge clk) disable iff (rst)
    (!ss_q && state != Q_IDLE) |=> state == Q_IDLE);
  assert_fault_blocks_start_R10: assert property (@(posedge clk) disable iff (rst)
    (fault && state == Q_IDLE) |=> state == Q_IDLE);
  assert_done_releases_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> state == Q_IDLE);
  assert_cs_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state == Q_RUN && $past(state) == Q_RUN) |-> $stable(cs_act));
endmodule

// File: tb/tb_spiq_master.sv
`timescale 1ns/1ps
module tb_spiq_master;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [3:0] cfg_idx = '0, rx_idx = '0;
  logic [15:0] cfg_wdata = '0, rx_rdata;
  logic miso, ss_n = 1'b1, sck_o, mosi_o, busy, done, fault;
  logic [3:0] cs_n_o;

  always #5 clk = ~clk;

  spiq_master dut (.clk, .rst, .cfg_we, .cfg_sel, .cfg_idx, .cfg_wdata,
    .rx_idx, .rx_rdata, .miso, .ss_n, .sck_o, .mosi_o, .cs_n_o,
    .busy, .done, .fault);

  int total = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench slave following the programmed mode
  logic b_cpol = 1'b0, b_cpha = 1'b0;
  logic [15:0] slv = '0, cap = '0;
  logic first = 1'b0, open_x = 1'b0, sck_at_sel = 1'b0;
  int nx = 0, last_sck = 0, rel_cyc = 0, sel_cyc = 0;
  logic [15:0] pats [8];
  logic [15:0] got [8];
  logic [3:0] seen_cs [8];
  assign miso = slv[15];

  always @(cs_n_o) begin
    if (open_x) begin
      if (nx < 8) got[nx] = cap;
      nx++; open_x = 1'b0; rel_cyc = cyc;
    end
    if (cs_n_o != 4'hF && nx < 8) begin
      slv = pats[nx]; seen_cs[nx] = cs_n_o; sck_at_sel = sck_o;
      first = 1'b1; cap = '0; open_x = 1'b1; sel_cyc = cyc;
    end
  end

  always @(sck_o) if (open_x) begin
    last_sck = cyc;
    if (b_cpha == 1'b0) begin
      if (sck_o != b_cpol) cap = {cap[14:0], mosi_o};
      else slv = slv << 1;
    end else begin
      if (sck_o != b_cpol) begin
        if (!first) slv = slv << 1;
        first = 1'b0;
      end else cap = {cap[14:0], mosi_o};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [3:0] i, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_idx = i; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic go(input logic [3:0] first_e, input logic [3:0] last_e);
    nx = 0;
    wr(3'd1, 4'd0, {1'b1, 7'd0, last_e, first_e});
  endtask

  task automatic wait_done();
    int c = 0;
    while (!done && c < 20000) begin @(negedge clk); c++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] i, output logic [15:0] v);
    rx_idx = i; @(negedge clk); @(negedge clk); v = rx_rdata;
  endtask

  function automatic logic [15:0] mode_w(input logic pol, input logic pha, input logic [3:0] code, input logic [7:0] hp);
    return {hp, 2'b00, code, pha, pol};
  endfunction

  task automatic t_reset();
    chk(sck_o == 1'b0 && mosi_o == 1'b0, "R1 pins", {sck_o, mosi_o}, 0);
    chk(cs_n_o == 4'hF, "R1 cs", cs_n_o, 4'hF);
    chk(!busy && !done && !fault, "R1 flags", {busy, done, fault}, 0);
  endtask

  task automatic t_idle();
    wr(3'd2, 4'd0, 16'h000B);
    repeat (2) @(negedge clk);
    chk(sck_o == 1'b1 && cs_n_o == 4'b0101, "R2 idle levels", {sck_o, cs_n_o}, 5'h15);
    wr(3'd2, 4'd0, 16'h001E);
    repeat (2) @(negedge clk);
    chk(sck_o == 1'b0 && cs_n_o == 4'hF, "R2 idle restore", {sck_o, cs_n_o}, 5'h0F);
  endtask

  task automatic t_basic();
    logic [15:0] v;
    b_cpol = 0; b_cpha = 0;
    wr(3'd0, 4'd0, mode_w(0, 0, 4'd12, 8'd2));
    wr(3'd4, 4'd3, 16'h000E);
    wr(3'd5, 4'd3, 16'h01A5);
    pats[0] = 16'h3C77;
    go(4'd3, 4'd3);
    wait_done();
    chk(nx == 1 && got[0][7:0] == 8'hA5, "R3 msb-first 8 bit tx", got[0][7:0], 8'hA5);
    chk(seen_cs[0] == 4'hE, "R11 cs pattern", seen_cs[0], 4'hE);
    rd(4'd3, v);
    chk(v == 16'h003C, "R6 rx at entry index", v, 16'h003C);
    chk(done && !busy && cs_n_o == 4'hF && sck_o == 1'b0, "R7 done release",
        {done, busy, cs_n_o, sck_o}, 7'h5E);
  endtask

  task automatic t_modes();
    logic [15:0] v;
    for (int m = 0; m < 4; m++) begin
      b_cpol = m[0]; b_cpha = m[1];
      wr(3'd2, 4'd0, {11'd0, 4'hF, b_cpol});
      wr(3'd0, 4'd0, mode_w(b_cpol, b_cpha, 4'd12, 8'd3));
      wr(3'd4, 4'd1, 16'h0017);
      wr(3'd5, 4'd1, 16'h0ABC);
      pats[0] = 16'h5A5F;
      go(4'd1, 4'd1);
      wait_done();
      chk(got[0][11:0] == 12'hABC, "R5 tx in mode", got[0][11:0], 12'hABC);
      chk(sck_at_sel == b_cpol, "R5 sck rest level", sck_at_sel, b_cpol);
      rd(4'd1, v);
      chk(v == 16'h05A5, "R4 12-bit rx in mode", v, 16'h05A5);
    end
    wr(3'd2, 4'd0, 16'h001E);
    b_cpol = 0; b_cpha = 0;
  endtask

  task automatic t_len16();
    logic [15:0] v;
    wr(3'd0, 4'd0, mode_w(0, 0, 4'd0, 8'd2));
    wr(3'd4, 4'd2, 16'h001D);
    wr(3'd5, 4'd2, 16'hBEEF);
    pats[0] = 16'h1234;
    go(4'd2, 4'd2);
    wait_done();
    chk(got[0] == 16'hBEEF, "R4 code 0 gives 16 bits tx", got[0], 16'hBEEF);
    rd(4'd2, v);
    chk(v == 16'h1234, "R4 code 0 gives 16 bits rx", v, 16'h1234);
    wr(3'd0, 4'd0, mode_w(0, 0, 4'd5, 8'd2));
    pats[0] = 16'hC3FF;
    go(4'd2, 4'd2);
    wait_done();
    rd(4'd2, v);
    chk(v == 16'h00C3, "R4 code 5 gives 8 bits", v, 16'h00C3);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(3'd0, 4'd0, mode_w(0, 0, 4'd0, 8'd2));
    wr(3'd4, 4'd14, 16'h000E); wr(3'd5, 4'd14, 16'h0011);
    wr(3'd4, 4'd15, 16'h000D); wr(3'd5, 4'd15, 16'h0022);
    wr(3'd4, 4'd0,  16'h000B); wr(3'd5, 4'd0,  16'h0033);
    wr(3'd4, 4'd1,  16'h0007); wr(3'd5, 4'd1,  16'h0044);
    pats[0] = 16'hA100; pats[1] = 16'hB200; pats[2] = 16'hC300; pats[3] = 16'hD400;
    go(4'd14, 4'd0);
    wait_done();
    chk(nx == 3, "R7 wrap stops at end entry", nx, 3);
    chk(seen_cs[0] == 4'hE && seen_cs[1] == 4'hD && seen_cs[2] == 4'hB, "R11 per-entry cs",
        {seen_cs[0], seen_cs[1], seen_cs[2]}, 12'hEDB);
    chk(got[1][7:0] == 8'h22 && got[2][7:0] == 8'h33, "R3 queued tx words",
        {got[1][7:0], got[2][7:0]}, 16'h2233);
    rd(4'd15, v); chk(v == 16'h00B2, "R6 rx entry 15", v, 16'h00B2);
    rd(4'd0, v);  chk(v == 16'h00C3, "R6 rx entry 0", v, 16'h00C3);
  endtask

  task automatic t_timing(input logic [7:0] hp, input int exp_half);
    int c, c2;
    wr(3'd0, 4'd0, mode_w(0, 0, 4'd8, hp));
    wr(3'd4, 4'd5, 16'h000E); wr(3'd5, 4'd5, 16'h0055);
    pats[0] = 16'h0;
    go(4'd5, 4'd5);
    c = 0; while (cs_n_o == 4'hF && c < 100) begin @(negedge clk); c++; end
    c = 0; while (sck_o == 1'b0 && c < 1000) begin @(negedge clk); c++; end
    chk(c >= exp_half, "R9 cs lead", c, exp_half);
    c2 = 0; while (sck_o == 1'b1 && c2 < 1000) begin @(negedge clk); c2++; end
    chk(c2 == exp_half, "R8 half period", c2, exp_half);
    wait_done();
    chk(rel_cyc - last_sck >= exp_half, "R9 cs lag", rel_cyc - last_sck, exp_half);
  endtask

  task automatic t_fault();
    wr(3'd0, 4'd0, mode_w(0, 0, 4'd0, 8'd15));
    wr(3'd4, 4'd6, 16'h001E); wr(3'd5, 4'd6, 16'hFFFF);
    pats[0] = 16'h0;
    go(4'd6, 4'd6);
    repeat (40) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    ss_n = 1'b1;
    chk(fault && !busy, "R10 fault stops queue", {fault, busy}, 2'b10);
    chk(cs_n_o == 4'hF && sck_o == 1'b0, "R10 pins idle after fault", {cs_n_o, sck_o}, 5'h1E);
    go(4'd6, 4'd6);
    repeat (4) @(negedge clk);
    chk(!busy && cs_n_o == 4'hF, "R10 start ignored while fault", {busy, cs_n_o}, 5'h0F);
    wr(3'd3, 4'd0, 16'h0002);
    @(negedge clk);
    chk(!fault, "R10 fault cleared", fault, 0);
    wr(3'd0, 4'd0, mode_w(0, 0, 4'd0, 8'd2));
    go(4'd6, 4'd6);
    wait_done();
    chk(done && nx == 1, "R10 restart after clear", {done, nx[3:0]}, 5'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_basic();
    t_modes();
    t_len16();
    t_wrap();
    t_timing(8'd5, 5);
    t_timing(8'd1, 2);
    t_fault();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule